// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block handles the even-parity side of a 32-bit multiplexed address/data bus for a device that can act either as initiator (master) or as target. Every clock it is told whether the bus is in an address phase or a data phase, which role the device holds and which way the data flows. From that it decides whether the device is the one driving AD and the byte-enable lines (so it must produce the parity bit) or the one sampling them (so it must check the parity bit that arrives one clock later).

When it drives, the parity bit appears one clock after the values it covers. When it samples, it stores the parity of the sampled values and compares it with the received parity bit on the next clock. A mismatch on a data phase pulls the data-parity-error line low for one clock; a mismatch on an address phase pulls the system-error line low for one clock. Both lines are open-drain and both are gated by bits of the command register. Separately, while the device is master of a write, a data-parity-error reported by the target two clocks after a data phase sets a sticky status bit. The transaction state machines that produce the phase and role qualifiers sit outside this block.

Top module: `pci_parity_unit`

## Requirements
- R1: The generated parity bit makes the total count of ones over the 32 AD bits, the 4 byte-enable bits and the parity bit even.
- R2: As master, the block drives the parity bit (par_oe_o high) in the clock after an address phase and in the clock after a write data phase, and does not drive it after a read data phase.
- R3: As target, the block drives the parity bit in the clock after a read data phase, and does not drive it after an address phase or a write data phase.
- R4: As master on a read data phase, a received parity bit (sampled in the next clock) that disagrees with the sampled AD/byte-enables asserts the data-parity-error output two clocks after the data phase, for exactly one clock; a matching parity bit asserts nothing.
- R5: As target on a write data phase, a parity mismatch asserts the data-parity-error output two clocks after the data phase, for one clock.
- R6: As target on an address phase, a parity mismatch asserts the system-error output two clocks after the address phase for one clock, only when both the system-error enable and the parity-error enable are set; an address-phase mismatch never asserts the data-parity-error output.
- R7: With the parity-error enable clear, a data-phase mismatch asserts no data-parity-error output.
- R8: The error outputs are open-drain: while asserted the output enable is high and the level is 0; otherwise the output enable is low (released).
- R9: When the target pulls the data-parity-error input low exactly two clocks after a master write data phase, the reported-error status bit is set in the following clock and stays set until reset; a low input at any other time does not set it.
- R10: After reset, no output is driven and the reported-error status bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| ad_i | input | 32 | Address/data bus value this clock |
| cbe_i | input | 4 | Command / byte-enable bus value this clock |
| par_i | input | 1 | Received parity bit |
| addr_phase_i | input | 1 | This clock is an address phase |
| data_phase_i | input | 1 | This clock is a completed data phase |
| master_i | input | 1 | Device is bus master (0 = target) |
| write_i | input | 1 | Transfer direction is write |
| perr_n_i | input | 1 | Data-parity-error line as seen on the bus, active low |
| perr_en_i | input | 1 | Command register parity-error response enable |
| serr_en_i | input | 1 | Command register system-error enable |
| par_o | output | 1 | Generated parity bit |
| par_oe_o | output | 1 | Drive enable for the parity bit |
| perr_n_o | output | 1 | Data-parity-error level, active low |
| perr_oe_o | output | 1 | Data-parity-error drive enable |
| serr_n_o | output | 1 | System-error level, active low |
| serr_oe_o | output | 1 | System-error drive enable |
| dpr_o | output | 1 | Sticky status: parity error reported by target during master write |

## Verification
Parity generation is tried with all-zero, all-one, alternating and walking-bit AD words under varied byte enables, so both odd and even ones counts appear and a wrong polarity or a dropped byte-enable bit shows up. Each role and direction is crossed with address and data phases, which separates drive phases from sample phases; checks use both correct and corrupted received parity so a checker that never or always flags is caught. The enable combinations (none, parity only, system only, both) tell apart the gating of the two error lines, and a low target error input placed one, two and three clocks after a master write isolates the two-clock window of the status bit.

// File: rtl/pci_par_pkg.sv
package pci_par_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic   drive;   // device owns AD/CBE this clock
        logic   check;   // device samples AD/CBE this clock
        logic   mwrite;  // master write data phase
        phase_e kind;
    } role_t;

    // even parity: returns the bit that makes the ones count even
    function automatic logic even_par(input logic [63:0] v);
        return ^v;
    endfunction

endpackage

// File: rtl/pci_par_role.sv
module pci_par_role
    import pci_par_pkg::*;
(
    input  logic  addr_phase,
    input  logic  data_phase,
    input  logic  master,
    input  logic  write,
    output role_t role
);
    always_comb begin
        role = '0;
        if (addr_phase) begin
            role.kind  = PH_ADDR;
            role.drive = master;
            role.check = ~master;
        end else if (data_phase) begin
            role.kind   = PH_DATA;
            role.drive  = master ? write : ~write;
            role.check  = master ? ~write : write;
            role.mwrite = master & write;
        end else begin
            role.kind = PH_IDLE;
        end
    end
endmodule

// File: rtl/pci_par_gen.sv
module pci_par_gen
    import pci_par_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            drive,
    output logic            par,
    output logic            par_oe
);
    localparam int SUM_W = AD_W + BE_W;

    logic [63:0] vec;
    always_comb begin
        vec = '0;
        vec[SUM_W-1:0] = {cbe, ad};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par    <= 1'b0;
            par_oe <= 1'b0;
        end else begin
            par    <= even_par(vec);
            par_oe <= drive;
        end
    end
endmodule

// File: rtl/pci_par_check.sv
module pci_par_check
    import pci_par_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe,
    input  logic            par_rx,
    input  role_t           role,
    input  logic            perr_en,
    input  logic            serr_en,
    output logic            perr_act,
    output logic            serr_act
);
    localparam int SUM_W = AD_W + BE_W;

    logic [63:0] vec;
    always_comb begin
        vec = '0;
        vec[SUM_W-1:0] = {cbe, ad};
    end

    // stage 1: capture parity of the sampled phase
    logic pend_v;
    logic pend_addr;
    logic pend_par;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_addr <= 1'b0;
            pend_par  <= 1'b0;
        end else begin
            pend_v    <= role.check;
            pend_addr <= (role.kind == PH_ADDR);
            pend_par  <= even_par(vec);
        end
    end

    // stage 2: compare with the parity bit arriving now, register report
    logic mismatch;
    assign mismatch = pend_v & (pend_par ^ par_rx);

    always_ff @(posedge clk) begin
        if (rst) begin
            perr_act <= 1'b0;
            serr_act <= 1'b0;
        end else begin
            perr_act <= mismatch & ~pend_addr & perr_en;
            serr_act <= mismatch &  pend_addr & perr_en & serr_en;
        end
    end
endmodule

// File: rtl/pci_par_dpr.sv
module pci_par_dpr #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mwrite,
    input  logic perr_n_in,
    output logic dpr
);
    logic [LAT-1:0] hist;

    generate
        if (LAT == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= mwrite;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) hist <= '0;
                else     hist <= {hist[LAT-2:0], mwrite};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)                                dpr <= 1'b0;
        else if (hist[LAT-1] && !perr_n_in)     dpr <= 1'b1;
    end
endmodule

// File: rtl/pci_parity_unit.sv
module pci_parity_unit
    import pci_par_pkg::*;
#(
    parameter int AD_W    = 32,
    parameter int BE_W    = 4,
    parameter int DPR_LAT = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad_i,
    input  logic [BE_W-1:0] cbe_i,
    input  logic            par_i,
    input  logic            addr_phase_i,
    input  logic            data_phase_i,
    input  logic            master_i,
    input  logic            write_i,
    input  logic            perr_n_i,
    input  logic            perr_en_i,
    input  logic            serr_en_i,
    output logic            par_o,
    output logic            par_oe_o,
    output logic            perr_n_o,
    output logic            perr_oe_o,
    output logic            serr_n_o,
    output logic            serr_oe_o,
    output logic            dpr_o
);
    role_t role;
    logic  perr_act;
    logic  serr_act;

    pci_par_role u_role (
        .addr_phase (addr_phase_i),
        .data_phase (data_phase_i),
        .master     (master_i),
        .write      (write_i),
        .role       (role)
    );

    pci_par_gen #(.AD_W(AD_W), .BE_W(BE_W)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .ad     (ad_i),
        .cbe    (cbe_i),
        .drive  (role.drive),
        .par    (par_o),
        .par_oe (par_oe_o)
    );

    pci_par_check #(.AD_W(AD_W), .BE_W(BE_W)) u_chk (
        .clk      (clk),
        .rst      (rst),
        .ad       (ad_i),
        .cbe      (cbe_i),
        .par_rx   (par_i),
        .role     (role),
        .perr_en  (perr_en_i),
        .serr_en  (serr_en_i),
        .perr_act (perr_act),
        .serr_act (serr_act)
    );

    pci_par_dpr #(.LAT(DPR_LAT)) u_dpr (
        .clk       (clk),
        .rst       (rst),
        .mwrite    (role.mwrite),
        .perr_n_in (perr_n_i),
        .dpr       (dpr_o)
    );

    // open-drain: low level while enabled, released otherwise
    assign perr_oe_o = perr_act;
    assign perr_n_o  = ~perr_act;
    assign serr_oe_o = serr_act;
    assign serr_n_o  = ~serr_act;
endmodule

// File: rtl/pci_parity_unit_chk.sv
module pci_parity_unit_chk #(
    parameter int AD_W = 32,
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst,
    input logic [AD_W-1:0] ad_i,
    input logic [BE_W-1:0] cbe_i,
    input logic            addr_phase_i,
    input logic            data_phase_i,
    input logic            master_i,
    input logic            write_i,
    input logic            perr_n_i,
    input logic            perr_en_i,
    input logic            serr_en_i,
    input logic            par_o,
    input logic            par_oe_o,
    input logic            perr_oe_o,
    input logic            serr_oe_o,
    input logic            dpr_o
);
    logic own_bus;
    assign own_bus = addr_phase_i ? master_i :
                     data_phase_i ? (master_i ? write_i : ~write_i) : 1'b0;

    assert_par_even_R1: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> ((^{$past(ad_i), $past(cbe_i), par_o}) == 1'b0));

    assert_par_owner_R2: assert property (@(posedge clk) disable iff (rst)
        par_oe_o |-> $past(own_bus));

    assert_perr_from_data_R4: assert property (@(posedge clk) disable iff (rst)
        perr_oe_o |-> ($past(data_phase_i, 2) && !$past(addr_phase_i, 2)));

    assert_serr_gate_R6: assert property (@(posedge clk) disable iff (rst)
        serr_oe_o |-> $past(perr_en_i && serr_en_i));

    assert_err_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(perr_oe_o && serr_oe_o));

    assert_perr_gate_R7: assert property (@(posedge clk) disable iff (rst)
        perr_oe_o |-> $past(perr_en_i));

    assert_dpr_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(dpr_o) |-> $past(!perr_n_i));

    assert_dpr_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        dpr_o |=> dpr_o);
endmodule

bind pci_parity_unit pci_parity_unit_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .ad_i         (ad_i),
    .cbe_i        (cbe_i),
    .addr_phase_i (addr_phase_i),
    .data_phase_i (data_phase_i),
    .master_i     (master_i),
    .write_i      (write_i),
    .perr_n_i     (perr_n_i),
    .perr_en_i    (perr_en_i),
    .serr_en_i    (serr_en_i),
    .par_o        (par_o),
    .par_oe_o     (par_oe_o),
    .perr_oe_o    (perr_oe_o),
    .serr_oe_o    (serr_oe_o),
    .dpr_o        (dpr_o)
);

// File: tb/pci_parity_unit_tb.sv
module pci_parity_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] ad_i = '0;
    logic [3:0]  cbe_i = '0;
    logic        par_i = 1'b0;
    logic        addr_phase_i = 1'b0;
    logic        data_phase_i = 1'b0;
    logic        master_i = 1'b0;
    logic        write_i = 1'b0;
    logic        perr_n_i = 1'b1;
    logic        perr_en_i = 1'b0;
    logic        serr_en_i = 1'b0;
    logic        par_o, par_oe_o, perr_n_o, perr_oe_o, serr_n_o, serr_oe_o, dpr_o;

    always #5 clk = ~clk;

    pci_parity_unit u_dut (
        .clk(clk), .rst(rst), .ad_i(ad_i), .cbe_i(cbe_i), .par_i(par_i),
        .addr_phase_i(addr_phase_i), .data_phase_i(data_phase_i),
        .master_i(master_i), .write_i(write_i), .perr_n_i(perr_n_i),
        .perr_en_i(perr_en_i), .serr_en_i(serr_en_i),
        .par_o(par_o), .par_oe_o(par_oe_o), .perr_n_o(perr_n_o),
        .perr_oe_o(perr_oe_o), .serr_n_o(serr_n_o), .serr_oe_o(serr_oe_o),
        .dpr_o(dpr_o)
    );

    typedef struct {
        logic  par_oe;
        logic  par;
        logic  perr;
        logic  serr;
        logic  dpr;
        string tag;
    } exp_t;

    exp_t sb[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // bench model state, derived from the requirements
    logic m_pend = 0, m_paddr = 0, m_ppar = 0;
    logic m_mw1 = 0, m_mw2 = 0, m_dpr = 0;

    task automatic check1(input string what, input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // drive one bus clock and push the outputs expected in the following clock
    task automatic apply(input logic m, input logic w, input logic ap, input logic dp,
                         input logic [31:0] ad, input logic [3:0] cbe, input logic pin,
                         input logic pe_n, input logic pen, input logic sen, input string tag);
        exp_t e;
        logic drv, chk, err, mw;
        @(negedge clk);
        master_i = m; write_i = w; addr_phase_i = ap; data_phase_i = dp;
        ad_i = ad; cbe_i = cbe; par_i = pin; perr_n_i = pe_n;
        perr_en_i = pen; serr_en_i = sen;
        drv = ap ? m : (dp ? (m ? w : ~w) : 1'b0);
        chk = ap ? ~m : (dp ? (m ? ~w : w) : 1'b0);
        mw  = ~ap & dp & m & w;
        err = m_pend & (m_ppar ^ pin);
        e.par_oe = drv;
        e.par    = ^{ad, cbe};
        e.perr   = err & ~m_paddr & pen;
        e.serr   = err & m_paddr & pen & sen;
        e.dpr    = m_dpr | (m_mw2 & ~pe_n);
        e.tag    = tag;
        sb.push_back(e);
        m_dpr = e.dpr; m_mw2 = m_mw1; m_mw1 = mw;
        m_pend = chk; m_paddr = ap; m_ppar = ^{ad, cbe};
    endtask

    function automatic logic gp(input logic [31:0] ad, input logic [3:0] cbe);
        return ^{ad, cbe};
    endfunction

    task automatic idle(input logic pin, input logic pe_n, input logic pen, input logic sen,
                        input string tag);
        apply(0, 0, 0, 0, 32'h0, 4'h0, pin, pe_n, pen, sen, tag);
    endtask

    // monitor: pops one expectation per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check1("par_oe", e.tag, par_oe_o, e.par_oe);
                if (e.par_oe) check1("par", e.tag, par_o, e.par);
                check1("perr_oe", e.tag, perr_oe_o, e.perr);
                if (e.perr) check1("perr_level", "R8", perr_n_o, 1'b0);
                check1("serr_oe", e.tag, serr_oe_o, e.serr);
                if (e.serr) check1("serr_level", "R8", serr_n_o, 1'b0);
                check1("dpr", e.tag, dpr_o, e.dpr);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check1("par_oe", "R10", par_oe_o, 1'b0);
        check1("perr_oe", "R10", perr_oe_o, 1'b0);
        check1("serr_oe", "R10", serr_oe_o, 1'b0);
        check1("dpr", "R10", dpr_o, 1'b0);

        // R1 / R2: master address then write data, varied patterns
        apply(1, 1, 1, 0, 32'h0000_0000, 4'h7, 0, 1, 1, 1, "R2");
        apply(1, 1, 0, 1, 32'hFFFF_FFFF, 4'h0, 0, 1, 1, 1, "R1");
        apply(1, 1, 0, 1, 32'hA5A5_5A5A, 4'h1, 0, 1, 1, 1, "R1");
        for (int i = 0; i < 32; i += 5)
            apply(1, 1, 0, 1, 32'h1 << i, 4'hF, 0, 1, 1, 1, "R1");
        // R2: master read data phases are not driven
        apply(1, 0, 0, 1, 32'h1234_5678, 4'h0, 0, 1, 1, 1, "R2");
        idle(gp(32'h1234_5678, 4'h0), 1, 1, 1, "R2");

        // R3: target read drives, target address / write does not
        apply(0, 0, 0, 1, 32'hDEAD_BEEF, 4'h3, 0, 1, 1, 1, "R3");
        apply(0, 1, 1, 0, 32'h0000_1000, 4'h3, 0, 1, 1, 1, "R3");
        apply(0, 1, 0, 1, 32'h0F0F_0F0F, 4'h0, gp(32'h0000_1000, 4'h3), 1, 1, 1, "R3");
        idle(gp(32'h0F0F_0F0F, 4'h0), 1, 1, 1, "R3");

        // R4: master read, good then bad parity, back-to-back
        apply(1, 0, 0, 1, 32'h8000_0001, 4'h0, 0, 1, 1, 0, "R4");
        apply(1, 0, 0, 1, 32'h7FFF_FFFE, 4'h2, gp(32'h8000_0001, 4'h0), 1, 1, 0, "R4");
        apply(1, 0, 0, 1, 32'h0000_00FF, 4'h0, ~gp(32'h7FFF_FFFE, 4'h2), 1, 1, 0, "R4");
        idle(~gp(32'h0000_00FF, 4'h0), 1, 1, 0, "R4");
        idle(0, 1, 1, 0, "R4");
        idle(0, 1, 1, 0, "R4");

        // R5: target write data with bad parity
        apply(0, 1, 0, 1, 32'hCAFE_F00D, 4'h5, 0, 1, 1, 0, "R5");
        idle(~gp(32'hCAFE_F00D, 4'h5), 1, 1, 0, "R5");
        idle(0, 1, 1, 0, "R5");

        // R6: target address errors under each enable combination
        apply(0, 0, 1, 0, 32'h0004_0000, 4'h6, 0, 1, 1, 1, "R6");
        idle(~gp(32'h0004_0000, 4'h6), 1, 1, 1, "R6");
        apply(0, 0, 1, 0, 32'h0004_0004, 4'h6, 0, 1, 1, 0, "R6");
        idle(~gp(32'h0004_0004, 4'h6), 1, 1, 0, "R6");
        apply(0, 0, 1, 0, 32'h0004_0008, 4'h6, 0, 1, 0, 1, "R6");
        idle(~gp(32'h0004_0008, 4'h6), 1, 0, 1, "R6");
        idle(0, 1, 0, 0, "R6");

        // R7: data error with parity enable clear
        apply(1, 0, 0, 1, 32'h3333_3333, 4'h0, 0, 1, 0, 1, "R7");
        idle(~gp(32'h3333_3333, 4'h0), 1, 0, 1, "R7");
        apply(0, 1, 0, 1, 32'h5555_0000, 4'h8, 0, 1, 0, 0, "R7");
        idle(~gp(32'h5555_0000, 4'h8), 1, 0, 0, "R7");
        idle(0, 1, 0, 0, "R7");

        // R9: error input low outside the window must not set status
        apply(1, 0, 0, 1, 32'h1111_1111, 4'h0, 0, 1, 1, 1, "R9");
        idle(gp(32'h1111_1111, 4'h0), 1, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");
        apply(1, 1, 0, 1, 32'h2222_2222, 4'h0, 0, 1, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");   // one clock after: ignored
        idle(0, 1, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");   // three clocks after: ignored
        idle(0, 1, 1, 1, "R9");
        // exact window: two clocks after a master write data phase
        apply(1, 1, 0, 1, 32'h4444_4444, 4'h0, 0, 1, 1, 1, "R9");
        idle(0, 1, 1, 1, "R9");
        idle(0, 0, 1, 1, "R9");
        idle(0, 1, 1, 1, "R9");
        idle(0, 1, 1, 1, "R9");
        idle(0, 1, 1, 1, "R9");

        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule